// File: doc/BRIEF.md
# Misalignment Exception Detector

This block decides, for every memory-access request, whether the access must raise an alignment exception. Each cycle it samples one request: the access class (for example a plain integer access, a floating-point access, a multiple-register transfer, a reservation access or a cache-block-zero), the low bits of the effective address, the access size, the byte-order mode, the attributes of the target page and the state of the data cache. It evaluates five class-specific rules. It does not apply one generic natural-alignment test. One clock later it presents a fault flag and a cause code to the exception unit.

The request side is a stream that has only a valid signal. The block accepts a request on every cycle and never applies back-pressure, so no ready signal exists. The result side carries `res_valid` exactly one cycle after each accepted request, and the consumer must take it in that cycle. Address translation and the access itself belong to other blocks.

Top module: `align_fault_det`

## Requirements
- R1: For the classes float (1), multiple (2), reserve (3) and external-control (4), a request whose address bits [1:0] are not both zero faults with cause 1. The class codes are plain 0, float 1, multiple 2, reserve 3, ext-control 4, string 5, block-zero 6.
- R2: A block-zero request (class 6) to a page that is marked cache-inhibited or write-through faults with cause 2.
- R3: A block-zero request issued while the data cache is locked or disabled faults with cause 3.
- R4: In little-endian mode (`le_mode`=1), a request whose address is not a multiple of its size faults with cause 4. The size codes are 0=1, 1=2, 2=4 and 3=8 bytes, and the size is checked against `req_addr_lo[2:0]`.
- R5: In little-endian mode, a multiple (2) or string (5) request faults with cause 5 whatever its address.
- R6: When several rules fire at once, the cause reported is the smallest code among them.
- R7: `res_valid` goes high in the cycle after each request with `req_valid`=1 and follows `req_valid` one cycle late. After a cycle without a request, `flt` is 0 and `flt_cause` is 0 (no fault).
- R8: While `rst_n` is low, `res_valid`, `flt` and `flt_cause` are all 0.
- R9: A plain integer request (class 0) in big-endian mode never faults, whatever its address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_class | input | 4 | Access class code |
| req_addr_lo | input | 3 | Low effective-address bits |
| req_size | input | 2 | Size code, log2 of the byte count |
| le_mode | input | 1 | 1 = little-endian mode |
| pg_inhibit | input | 1 | Page is cache-inhibited |
| pg_wthru | input | 1 | Page is write-through |
| dc_locked | input | 1 | Data cache is locked |
| dc_off | input | 1 | Data cache is disabled |
| res_valid | output | 1 | Result of the previous cycle's request |
| flt | output | 1 | Alignment fault |
| flt_cause | output | 3 | Cause code, 0 when there is no fault |

## Verification
The hardest condition to produce is one where three or four rules overlap. An example is a little-endian block-zero to a misaligned address on an inhibited page while the cache is locked, because only the priority order then decides the reported cause. The stimulus sweeps every class, address, size and byte order. It turns the four page and cache attribute bits with a counter that moves at a stride unrelated to the sweep, so those bits meet most combinations of the other fields. Directed requests then stack the overlapping rules deliberately. The sweep also inserts idle cycles to check that the result clears and lines up with its request.

// File: rtl/align_pkg.sv
package align_pkg;

  typedef enum logic [3:0] {
    ACC_PLAIN   = 4'd0,
    ACC_FLOAT   = 4'd1,
    ACC_MULTI   = 4'd2,
    ACC_RESV    = 4'd3,
    ACC_EXTCTL  = 4'd4,
    ACC_STRING  = 4'd5,
    ACC_BLKZERO = 4'd6
  } acc_class_e;

  localparam int unsigned RULE_CNT = 5;
  localparam int unsigned CAUSE_W  = $clog2(RULE_CNT + 1);

  // Rule index k (0-based) is reported as cause k+1; lower index wins.
  localparam int unsigned RULE_WORD     = 0;
  localparam int unsigned RULE_BZ_ATTR  = 1;
  localparam int unsigned RULE_BZ_CACHE = 2;
  localparam int unsigned RULE_LE_MISAL = 3;
  localparam int unsigned RULE_LE_MULTI = 4;

endpackage

// File: rtl/align_word_chk.sv
module align_word_chk #(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned CLASS_W    = 4,
  localparam int unsigned WORD_LSB  = $clog2(WORD_BYTES)
) (
  input  logic [CLASS_W-1:0]  cls_i,
  input  logic [WORD_LSB-1:0] addr_i,
  output logic                hit_o
);
  import align_pkg::*;

  logic word_class;

  always_comb begin
    unique case (acc_class_e'(cls_i))
      ACC_FLOAT, ACC_MULTI, ACC_RESV, ACC_EXTCTL: word_class = 1'b1;
      default:                                    word_class = 1'b0;
    endcase
  end

  assign hit_o = word_class && (|addr_i);
endmodule

// File: rtl/align_blkzero_chk.sv
module align_blkzero_chk #(
  parameter int unsigned CLASS_W = 4
) (
  input  logic [CLASS_W-1:0] cls_i,
  input  logic               pg_inhibit_i,
  input  logic               pg_wthru_i,
  input  logic               dc_locked_i,
  input  logic               dc_off_i,
  output logic               attr_hit_o,
  output logic               cache_hit_o
);
  import align_pkg::*;

  logic is_bz;

  assign is_bz       = (acc_class_e'(cls_i) == ACC_BLKZERO);
  assign attr_hit_o  = is_bz && (pg_inhibit_i || pg_wthru_i);
  assign cache_hit_o = is_bz && (dc_locked_i || dc_off_i);
endmodule

// File: rtl/align_le_chk.sv
module align_le_chk #(
  parameter int unsigned ADDR_LO_W = 3,
  parameter int unsigned SIZE_W    = 2,
  parameter int unsigned CLASS_W   = 4
) (
  input  logic [CLASS_W-1:0]   cls_i,
  input  logic [ADDR_LO_W-1:0] addr_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic                 le_i,
  output logic                 misal_hit_o,
  output logic                 multi_hit_o
);
  import align_pkg::*;

  logic [ADDR_LO_W-1:0] size_mask;

  // Bit j of the mask is set when the access spans more than 2^j bytes.
  for (genvar j = 0; j < ADDR_LO_W; j++) begin : g_mask
    assign size_mask[j] = (32'(j) < 32'(size_i));
  end

  logic is_multi;
  always_comb begin
    unique case (acc_class_e'(cls_i))
      ACC_MULTI, ACC_STRING: is_multi = 1'b1;
      default:               is_multi = 1'b0;
    endcase
  end

  assign misal_hit_o = le_i && (|(addr_i & size_mask));
  assign multi_hit_o = le_i && is_multi;
endmodule

// File: rtl/align_prio_enc.sv
module align_prio_enc #(
  parameter int unsigned N      = 5,
  localparam int unsigned CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      hit_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_i[k]) code_o = CODE_W'(k + 1);
    end
  end
endmodule

// File: rtl/align_fault_det.sv
module align_fault_det #(
  parameter int unsigned ADDR_LO_W  = 3,
  parameter int unsigned SIZE_W     = 2,
  parameter int unsigned CLASS_W    = 4,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WORD_LSB  = $clog2(WORD_BYTES),
  localparam int unsigned CW        = align_pkg::CAUSE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CLASS_W-1:0]   req_class,
  input  logic [ADDR_LO_W-1:0] req_addr_lo,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 le_mode,
  input  logic                 pg_inhibit,
  input  logic                 pg_wthru,
  input  logic                 dc_locked,
  input  logic                 dc_off,
  output logic                 res_valid,
  output logic                 flt,
  output logic [CW-1:0]        flt_cause
);
  import align_pkg::*;

  logic [RULE_CNT-1:0] hit;
  logic [CW-1:0]       code;

  align_word_chk #(
    .WORD_BYTES(WORD_BYTES),
    .CLASS_W   (CLASS_W)
  ) u_word (
    .cls_i (req_class),
    .addr_i(req_addr_lo[WORD_LSB-1:0]),
    .hit_o (hit[RULE_WORD])
  );

  align_blkzero_chk #(
    .CLASS_W(CLASS_W)
  ) u_bz (
    .cls_i       (req_class),
    .pg_inhibit_i(pg_inhibit),
    .pg_wthru_i  (pg_wthru),
    .dc_locked_i (dc_locked),
    .dc_off_i    (dc_off),
    .attr_hit_o  (hit[RULE_BZ_ATTR]),
    .cache_hit_o (hit[RULE_BZ_CACHE])
  );

  align_le_chk #(
    .ADDR_LO_W(ADDR_LO_W),
    .SIZE_W   (SIZE_W),
    .CLASS_W  (CLASS_W)
  ) u_le (
    .cls_i      (req_class),
    .addr_i     (req_addr_lo),
    .size_i     (req_size),
    .le_i       (le_mode),
    .misal_hit_o(hit[RULE_LE_MISAL]),
    .multi_hit_o(hit[RULE_LE_MULTI])
  );

  align_prio_enc #(
    .N(RULE_CNT)
  ) u_prio (
    .hit_i (hit),
    .code_o(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      flt       <= 1'b0;
      flt_cause <= '0;
    end else begin
      res_valid <= req_valid;
      flt       <= req_valid && (|hit);
      flt_cause <= req_valid ? code : '0;
    end
  end
endmodule

// File: rtl/align_fault_chk.sv
module align_fault_chk #(
  parameter int unsigned ADDR_LO_W  = 3,
  parameter int unsigned SIZE_W     = 2,
  parameter int unsigned CLASS_W    = 4,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned CW        = align_pkg::CAUSE_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [CLASS_W-1:0]   req_class,
  input logic [ADDR_LO_W-1:0] req_addr_lo,
  input logic [SIZE_W-1:0]    req_size,
  input logic                 le_mode,
  input logic                 pg_inhibit,
  input logic                 pg_wthru,
  input logic                 dc_locked,
  input logic                 dc_off,
  input logic                 res_valid,
  input logic                 flt,
  input logic [CW-1:0]        flt_cause
);
  logic word_cls;
  assign word_cls = (req_class == 1) || (req_class == 2) ||
                    (req_class == 3) || (req_class == 4);

  assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && word_cls && (req_addr_lo[1:0] != 2'b00) |=> flt && (flt_cause == 1));

  assert_bz_attr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_class == 6) && (pg_inhibit || pg_wthru) |=> flt && (flt_cause == 2));

  assert_bz_cache_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_class == 6) && !pg_inhibit && !pg_wthru && (dc_locked || dc_off)
    |=> flt && (flt_cause == 3));

  assert_le_string_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && le_mode && (req_class == 5) && (req_size == 0) |=> flt && (flt_cause == 5));

  assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !flt && (flt_cause == 0));

  assert_plain_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_class == 0) && !le_mode |=> !flt && (flt_cause == 0));

  assert_flag_matches_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flt == (flt_cause != 0)));
endmodule

bind align_fault_det align_fault_chk #(
  .ADDR_LO_W (ADDR_LO_W),
  .SIZE_W    (SIZE_W),
  .CLASS_W   (CLASS_W),
  .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/tb_align_fault_det.sv
module tb_align_fault_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_class = '0;
  logic [2:0] req_addr_lo = '0;
  logic [1:0] req_size = '0;
  logic       le_mode = 1'b0, pg_inhibit = 1'b0, pg_wthru = 1'b0;
  logic       dc_locked = 1'b0, dc_off = 1'b0;
  logic       res_valid, flt;
  logic [2:0] flt_cause;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit       vld;
    bit [2:0] cause;
    string    tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  align_fault_det dut (.*);

  // Independent reference from the requirement text.
  function automatic bit [2:0] model(int cls, int a, int sz, bit le,
                                     bit ci, bit wt, bit lk, bit dis);
    if ((cls >= 1 && cls <= 4) && (a % 4) != 0) return 3'd1;  // R1
    if (cls == 6 && (ci || wt))                  return 3'd2;  // R2
    if (cls == 6 && (lk || dis))                 return 3'd3;  // R3
    if (le && (a % (1 << sz)) != 0)              return 3'd4;  // R4
    if (le && (cls == 2 || cls == 5))            return 3'd5;  // R5
    return 3'd0;                                               // R9
  endfunction

  function automatic string tag_of(bit [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic send(int cls, int a, int sz, bit le, bit ci, bit wt,
                      bit lk, bit dis, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_class = 4'(cls); req_addr_lo = 3'(a); req_size = 2'(sz);
    le_mode = le; pg_inhibit = ci; pg_wthru = wt; dc_locked = lk; dc_off = dis;
    e.vld = 1'b1;
    e.cause = model(cls, a, sz, le, ci, wt, lk, dis);
    e.tag = (tag == "") ? tag_of(e.cause) : tag;
    q.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    req_valid = 1'b0;
    req_class = 4'd2; le_mode = 1'b1; req_addr_lo = 3'd3;  // would fault if taken
    e.vld = 1'b0; e.cause = 3'd0; e.tag = "R7";
    q.push_back(e);
  endtask

  // Monitor: scoreboard comparison, away from the clock edge.
  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (res_valid !== e.vld || flt !== (e.cause != 0) || flt_cause !== e.cause) begin
          errors++;
          $display("FAIL %s: got valid=%0b flt=%0b cause=%0d expected valid=%0b flt=%0b cause=%0d",
                   e.tag, res_valid, flt, flt_cause, e.vld, (e.cause != 0), e.cause);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n = 0;
    // R8: outputs stay clear during reset, even with a faulting request present.
    req_valid = 1'b1; req_class = 4'd1; req_addr_lo = 3'd1;
    repeat (3) begin
      @(posedge clk); #2;
      checks++;
      if (res_valid !== 1'b0 || flt !== 1'b0 || flt_cause !== 3'd0) begin
        errors++;
        $display("FAIL R8: got valid=%0b flt=%0b cause=%0d expected 0 0 0",
                 res_valid, flt, flt_cause);
      end
    end
    @(negedge clk); req_valid = 1'b0; rst_n = 1'b1;

    // Sweep: all classes, addresses, sizes, byte orders; attributes rotated.
    for (int cls = 0; cls < 7; cls++)
      for (int a = 0; a < 8; a++)
        for (int sz = 0; sz < 4; sz++)
          for (int le = 0; le < 2; le++) begin
            n += 7;
            send(cls, a, sz, le[0], n[0], n[2], n[1], n[3], "");
            if ((n % 5) == 0) idle();  // R7: gaps between requests
          end

    // R6: overlapping rules, lowest code reported.
    send(6, 3, 3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6");  // 2,3,4 fire -> 2
    send(6, 1, 1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");  // 3,4 fire -> 3
    send(2, 2, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");  // 1,4,5 fire -> 1
    send(5, 2, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");  // 4,5 fire -> 4
    send(2, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R9: plain big-endian at odd addresses with all attributes set.
    send(0, 7, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
    idle();
    idle();
    send(3, 4, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    idle();

    wait (q.size() == 0);
    @(posedge clk); #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule